// File: doc/BRIEF.md
# Register-Mapped Real-Time Counter with Two Alarms

This block is a real-time counter peripheral that sits on a simple 32-bit register port. The port reads in the same cycle and writes on the next clock. A 32.768 kHz enable pulse drives a programmable prescaler. The prescaler emits one advance for every 2×(divider+1) enable pulses. Each advance increments a free-running 32-bit counter. With a divider of 1023 the counter steps at 16 Hz. At that rate the low 4 bits count sixteenths of a second and the upper 28 bits count whole seconds.

Two alarm comparators watch the counter. A periodic tick event also sets a flag. The alarm flags, the tick flag and their enables share one status word. Software clears a flag by writing 1 to it. A flag that is set while its enable is on holds the interrupt line high. Software can also use a 2-bit clock-select register and a 32-bit scratch word. The scratch word lets software count counter wraps, and it keeps whatever value was last written to it.

Top module: `wake_rtc`

## Requirements
- R1: After reset the counter, both alarms, status, clock select and scratch read 0, the divider reads DIV_RST (1023 by default), and irq_o is 0.
- R2: With the divider at d, the counter advances by exactly 1 on the 2×(d+1)-th enable pulse since the last advance. It does not change without enable pulses.
- R3: The counter wraps from 0xFFFFFFFF to 0 on an advance.
- R4: A bus write to the counter (offset 0x00) appears at the next clock. It restarts the prescaler phase, so the next advance needs a full 2×(d+1) pulses.
- R5: Alarm0 is at offset 0x04. Its flag is status bit 0 and its enable is status bit 2. The flag is set on the advance that brings the counter to the alarm0 value, but only if the enable is 1.
- R6: Alarm1 is at offset 0x18. Its flag is status bit 4 and its enable is status bit 6. It behaves the same way as alarm0.
- R7: The tick flag is status bit 1 and its enable is status bit 3. The flag is set on every advance while the enable is 1.
- R8: The status word is at offset 0x08. Writing 1 to flag bits 0, 1 or 4 clears that flag, and writing 0 leaves it unchanged. Bits 2, 3 and 6 are read/write. All other bits read 0.
- R9: irq_o is high while any flag is set together with its enable. It stays high until that flag is cleared.
- R10: Clock select at offset 0x1C holds 2 bits, and its upper bits read 0. The divider is at 0x0C. The scratch word at 0x40 returns the last value written to it.
- R11: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en32k_i | input | 1 | One-cycle enable pulse at 32.768 kHz |
| req_i | input | 1 | Bus write strobe qualifier |
| we_i | input | 1 | Write enable |
| addr_i | input | 7 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that a bus write and an enable pulse never land on the same clock, since a counter write throws away a coincident pulse. They also assume that en32k_i is a single-cycle pulse. The stimulus raises the enable for one cycle and returns it low before any bus access. Every register write is issued between pulses. The divider sweep uses small divider values so that every phase count can be counted pulse by pulse.

// File: rtl/wake_rtc_pkg.sv
package wake_rtc_pkg;
  localparam int ADDR_W    = 7;
  localparam int NUM_ALARM = 2;

  localparam logic [ADDR_W-1:0] OFS_CNT     = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_ST      = 7'h08;
  localparam logic [ADDR_W-1:0] OFS_DIV     = 7'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLKSEL  = 7'h1C;
  localparam logic [ADDR_W-1:0] OFS_SCRATCH = 7'h40;

  localparam int TICK_FLAG_BIT = 1;
  localparam int TICK_EN_BIT   = 3;

  function automatic logic [ADDR_W-1:0] alarm_ofs(input int idx);
    return (idx == 0) ? 7'h04 : 7'h18;
  endfunction

  function automatic int alarm_flag_bit(input int idx);
    return (idx == 0) ? 0 : 4;
  endfunction

  function automatic int alarm_en_bit(input int idx);
    return (idx == 0) ? 2 : 6;
  endfunction
endpackage

// File: rtl/wake_rtc_presc.sv
module wake_rtc_presc #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int PH_W = DIV_W + 1;

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] limit;

  assign limit  = {div_i, 1'b1};  // 2*(div+1)-1
  // >= so a divider lowered mid-period still terminates
  assign tick_o = en_i && !restart_i && (phase_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (en_i)      phase_q <= tick_o ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/wake_rtc_cmp.sv
module wake_rtc_cmp #(
  parameter int CNT_W = 32
) (
  input  logic [CNT_W-1:0] cnt_next_i,
  input  logic             adv_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] alarm_i,
  output logic             match_o
);
  assign match_o = adv_i && en_i && (cnt_next_i == alarm_i);
endmodule

// File: rtl/wake_rtc.sv
module wake_rtc
  import wake_rtc_pkg::*;
#(
  parameter int          CNT_W   = 32,
  parameter int          DIV_W   = 16,
  parameter int unsigned DIV_RST = 1023
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en32k_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic [CNT_W-1:0] alarm_q [NUM_ALARM];
  logic [DIV_W-1:0] div_q;
  logic [1:0]       clksel_q;
  logic [31:0]      scratch_q;
  logic [NUM_ALARM-1:0] aflag_q, aen_q, amatch;
  logic             tflag_q, ten_q;
  logic             tick;
  logic             wr, wr_cnt, wr_st;
  logic [31:0]      st_word;

  assign wr       = req_i && we_i;
  assign wr_cnt   = wr && (addr_i == OFS_CNT);
  assign wr_st    = wr && (addr_i == OFS_ST);
  assign cnt_next = cnt_q + 1'b1;

  wake_rtc_presc #(.DIV_W(DIV_W)) presc_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en32k_i),
    .div_i    (div_q),
    .restart_i(wr_cnt),
    .tick_o   (tick)
  );

  for (genvar g = 0; g < NUM_ALARM; g++) begin : g_alarm
    localparam int FB = alarm_flag_bit(g);
    localparam int EB = alarm_en_bit(g);
    localparam logic [ADDR_W-1:0] AOFS = alarm_ofs(g);

    wake_rtc_cmp #(.CNT_W(CNT_W)) cmp_i (
      .cnt_next_i(cnt_next),
      .adv_i     (tick),
      .en_i      (aen_q[g]),
      .alarm_i   (alarm_q[g]),
      .match_o   (amatch[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        alarm_q[g] <= '0;
        aen_q[g]   <= 1'b0;
        aflag_q[g] <= 1'b0;
      end else begin
        if (wr && addr_i == AOFS) alarm_q[g] <= wdata_i[CNT_W-1:0];
        if (wr_st) aen_q[g] <= wdata_i[EB];
        // a new match wins over a simultaneous clear
        if (amatch[g])                 aflag_q[g] <= 1'b1;
        else if (wr_st && wdata_i[FB]) aflag_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      div_q     <= DIV_INIT;
      clksel_q  <= '0;
      scratch_q <= '0;
      ten_q     <= 1'b0;
      tflag_q   <= 1'b0;
    end else begin
      if (wr_cnt)    cnt_q <= wdata_i[CNT_W-1:0];
      else if (tick) cnt_q <= cnt_next;
      if (wr && addr_i == OFS_DIV)     div_q     <= wdata_i[DIV_W-1:0];
      if (wr && addr_i == OFS_CLKSEL)  clksel_q  <= wdata_i[1:0];
      if (wr && addr_i == OFS_SCRATCH) scratch_q <= wdata_i;
      if (wr_st) ten_q <= wdata_i[TICK_EN_BIT];
      if (tick && ten_q)                          tflag_q <= 1'b1;
      else if (wr_st && wdata_i[TICK_FLAG_BIT])   tflag_q <= 1'b0;
    end
  end

  always_comb begin
    st_word = '0;
    st_word[TICK_FLAG_BIT] = tflag_q;
    st_word[TICK_EN_BIT]   = ten_q;
    for (int i = 0; i < NUM_ALARM; i++) begin
      st_word[alarm_flag_bit(i)] = aflag_q[i];
      st_word[alarm_en_bit(i)]   = aen_q[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CNT:     rdata_o = 32'(cnt_q);
      OFS_ST:      rdata_o = st_word;
      OFS_DIV:     rdata_o = 32'(div_q);
      OFS_CLKSEL:  rdata_o = {30'b0, clksel_q};
      OFS_SCRATCH: rdata_o = scratch_q;
      default: begin
        for (int i = 0; i < NUM_ALARM; i++)
          if (addr_i == alarm_ofs(i)) rdata_o = 32'(alarm_q[i]);
      end
    endcase
  end

  assign irq_o = |(aflag_q & aen_q) | (tflag_q & ten_q);
endmodule

// File: rtl/wake_rtc_chk.sv
module wake_rtc_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick_i,
  input logic             wr_cnt_i,
  input logic             wr_st_i,
  input logic [31:0]      wdata_i,
  input logic             aflag0_i,
  input logic             aen0_i,
  input logic             match0_i,
  input logic             irq_i
);
  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_cnt_i) |=> cnt_i == $past(cnt_i) + 1'b1);

  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_cnt_i) |=> $stable(cnt_i));

  p_cnt_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> cnt_i == $past(wdata_i[CNT_W-1:0]));

  p_alarm_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aen0_i && !aflag0_i) |=> !aflag0_i);

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st_i && wdata_i[0] && !match0_i) |=> !aflag0_i);

  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !wr_st_i) |=> irq_i);
endmodule

bind wake_rtc wake_rtc_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_i   (cnt_q),
  .tick_i  (tick),
  .wr_cnt_i(wr_cnt),
  .wr_st_i (wr_st),
  .wdata_i (wdata_i),
  .aflag0_i(aflag_q[0]),
  .aen0_i  (aen_q[0]),
  .match0_i(amatch[0]),
  .irq_i   (irq_o)
);

// File: tb/wake_rtc_tb_top.sv
`timescale 1ns/1ps
module wake_rtc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en32k_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  wake_rtc dut_i (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; req_i = 1'b1; we_i = 1'b1;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse();
    en32k_i = 1'b1;
    @(posedge clk_i); #1;
    en32k_i = 1'b0;
    @(posedge clk_i); #1;
  endtask

  task automatic adv(input int d);
    repeat (2 * (d + 1)) pulse();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base;
    repeat (3) @(posedge clk_i); #1;
    rst_ni = 1'b1;

    // R1 reset state
    rd(7'h00, v); chk("R1 cnt", v, 0);
    rd(7'h04, v); chk("R1 alarm0", v, 0);
    rd(7'h18, v); chk("R1 alarm1", v, 0);
    rd(7'h08, v); chk("R1 status", v, 0);
    rd(7'h0C, v); chk("R1 div", v, 1023);
    rd(7'h1C, v); chk("R1 clksel", v, 0);
    rd(7'h40, v); chk("R1 scratch", v, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);

    // R2 divider sweep: pulses per advance = 2*(d+1)
    for (int d = 0; d < 6; d++) begin
      int k;
      base = 32'h1000 * d + 7;
      wr(7'h0C, d);
      wr(7'h00, base);
      k = 0;
      do begin pulse(); k++; rd(7'h00, v); end while (v == base && k < 100);
      chk("R2 advance value", v, base + 1);
      chk("R2 pulses per advance", k, 2 * (d + 1));
    end
    repeat (20) @(posedge clk_i); #1;
    rd(7'h00, v); chk("R2 idle hold", v, 32'h5008);

    // R3 wrap
    wr(7'h0C, 0);
    wr(7'h00, 32'hFFFF_FFFF);
    adv(0);
    rd(7'h00, v); chk("R3 wrap", v, 0);

    // R4 write restarts phase
    wr(7'h0C, 1);
    wr(7'h00, 10);
    repeat (3) pulse();
    wr(7'h00, 100);
    rd(7'h00, v); chk("R4 write visible", v, 100);
    repeat (3) pulse();
    rd(7'h00, v); chk("R4 phase restarted", v, 100);
    pulse();
    rd(7'h00, v); chk("R4 full period", v, 101);

    // R5/R6 alarm sweep
    wr(7'h0C, 0);
    for (int i = 0; i < 2; i++) begin
      for (int en = 0; en < 2; en++) begin
        logic [6:0]  aofs;
        logic [31:0] fbit, ebit;
        string r;
        aofs = (i == 0) ? 7'h04 : 7'h18;
        fbit = (i == 0) ? 32'h01 : 32'h10;
        ebit = (i == 0) ? 32'h04 : 32'h40;
        r    = (i == 0) ? "R5" : "R6";
        wr(7'h08, 32'h13 | (en ? ebit : 0));
        wr(7'h00, 50 + 10 * i);
        wr(aofs, 52 + 10 * i);
        rd(aofs, v); chk({r, " alarm readback"}, v, 52 + 10 * i);
        adv(0);
        rd(7'h08, v); chk({r, " not early"}, v & fbit, 0);
        adv(0);
        rd(7'h08, v); chk({r, " flag on match"}, v & fbit, en ? fbit : 0);
        chk("R9 irq on alarm", {31'b0, irq_o}, en);
        adv(0);
        chk("R9 irq held", {31'b0, irq_o}, en);
        wr(7'h08, (en ? ebit : 0) | fbit);
        rd(7'h08, v); chk("R8 alarm w1c", v & fbit, 0);
        chk("R9 irq released", {31'b0, irq_o}, 0);
      end
    end

    // R7 tick flag
    wr(7'h08, 32'h13);
    adv(0);
    rd(7'h08, v); chk("R7 tick disabled", v & 2, 0);
    wr(7'h08, 32'h08);
    adv(0);
    rd(7'h08, v); chk("R7 tick flag", v & 2, 2);
    chk("R9 irq on tick", {31'b0, irq_o}, 1);
    wr(7'h08, 32'h08);
    rd(7'h08, v); chk("R8 write 0 keeps flag", v & 2, 2);
    wr(7'h0C, 3);
    wr(7'h08, 32'h0A);
    rd(7'h08, v); chk("R8 tick w1c", v, 32'h08);
    chk("R9 irq cleared", {31'b0, irq_o}, 0);

    // R8 reserved bits / enables
    wr(7'h08, 32'hFFFF_FFFF);
    rd(7'h08, v); chk("R8 enables only", v, 32'h4C);
    wr(7'h08, 32'h0);
    rd(7'h08, v); chk("R8 enables clear", v, 0);

    // R10 clksel, scratch, divider
    wr(7'h1C, 32'hFFFF_FFFF);
    rd(7'h1C, v); chk("R10 clksel 2 bits", v, 3);
    rd(7'h0C, v); chk("R10 divider readback", v, 3);
    for (int s = 0; s < 4; s++) begin
      wr(7'h40, 32'hA5A5_0000 ^ (32'h1 << (s * 8)));
      rd(7'h40, v); chk("R10 scratch", v, 32'hA5A5_0000 ^ (32'h1 << (s * 8)));
    end

    // R11 unmapped offsets
    for (int a = 0; a < 128; a += 4) begin
      if (a == 0 || a == 4 || a == 8 || a == 12 || a == 24 || a == 28 || a == 64) continue;
      wr(a[6:0], 32'hDEAD_BEEF);
      rd(a[6:0], v); chk("R11 unmapped read", v, 0);
    end
    rd(7'h40, v); chk("R11 scratch untouched", v, 32'hA4A5_0000);
    rd(7'h1C, v); chk("R11 clksel untouched", v, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule